// File: doc/BRIEF.md
# TDM Slot Transmitter with Deferred Configuration

This block drives the transmit side of a time-division-multiplexed serial audio link. At every sample period it captures three 16-bit words (a status word, a left sample and a right sample). It then shifts them out MSB first into three consecutive 16-bit slots, counted from a frame-sync pulse. A frame holds either 32 slots, which is two sample periods per frame sync, or 16 slots, which is one sample period. The data output enable is high only while the block's own slots are on the wire, so the line can be shared with other talkers.

Two configuration bits choose the frame size and which slot group the block uses. Slots 3 to 5 suit a single shared data wire. Slots 0 to 2 suit separate input and output wires. Software writes these bits through a small register port, but only while the mode-change gate input is high. An accepted write lands in a shadow copy and reaches the transmitter only at the next frame-sync pulse. Because of this, a frame is never reshaped part-way through, including the second sample period of a 32-slot frame. Two index addresses are dead: writes to them do nothing, and reads from them return the live status word.

Top module: `tdm_slot_tx`

## Requirements
- R1: After reset the configuration byte reads 00h (32-slot frames, slots 3 to 5) and `sdo_oe` is low until the first frame sync.
- R2: A write to the configuration address (12) while `mce` is low changes neither the read-back value nor the output pattern.
- R3: A write to address 12 with `mce` high is visible on read-back in the next cycle. It governs the output only from the next frame-sync pulse on. A write made in the same cycle as a frame-sync pulse waits for the following pulse.
- R4: Configuration bit 0 (frame size): 0 gives 32 slots of 16 bits (512 clocks) per frame, in two sample periods starting at slot 0 and slot 16. 1 gives 16 slots (256 clocks), with one sample period.
- R5: Configuration bit 1 (slot group): 0 places status, left and right in slots 3, 4 and 5 of each sample period. 1 places them in slots 0, 1 and 2.
- R6: In 32-slot mode, a configuration change written during the first sample period of a frame does not alter the second sample period of that frame. The second period repeats the pattern of the first, offset by 16 slots.
- R7: The clock edge that samples `fsync` high is bit position 0. From the next cycle on, `sdo` carries the bit at position p = clocks since that edge, with each word shifted MSB first. `sdo_oe` is high exactly during the block's own three slots.
- R8: The three words are captured on the edge that starts each sample period (position 0, and position 256 in 32-slot mode). Changes to the word inputs later in the period do not affect the bits sent.
- R9: Addresses 14 and 15 ignore writes, and a read of either returns `status_word`. Reads of any other address except 12 return zero.
- R10: Bits 7 to 2 of the configuration byte are reserved: they are stored as zero whatever is written.
- R11: When the frame length has elapsed without a new frame-sync pulse, `sdo_oe` stays low until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse, one clock wide, marks bit position 0 |
| mce | input | 1 | Mode-change gate; configuration writes count only while high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register index for reads and writes |
| wr_data | input | 8 | Register write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| status_word | input | 16 | Word sent in the first slot of the group |
| left_word | input | 16 | Word sent in the second slot of the group |
| right_word | input | 16 | Word sent in the third slot of the group |
| sdo | output | 1 | Serial data out, MSB first |
| sdo_oe | output | 1 | Drive enable for `sdo` |

## Verification
The bench goes after the commit edge. One write arrives in the first half of a 32-slot frame, and a design that committed at slot 16 would move the second-half burst early. Another write lands on the frame-sync cycle itself, and a design that let it through would switch one frame too soon. Gated writes, writes to the dead addresses and writes with reserved bits set are each followed by read-back and by whole frames of output, which catches a leaky gate or a stored reserved bit. Word inputs change in the middle of sample periods, and frames run past their length without a new pulse. This exposes a design that reads words live or keeps driving after the frame has ended.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    // Active transmit configuration as applied by the shifter
    typedef struct packed {
        logic grp_low;      // 1: slots 0..2, 0: slots 3..5
        logic short_frame;  // 1: 16 slots per frame, 0: 32 slots
    } tx_cfg_t;

    localparam int CFG_GRP_BIT   = 1;
    localparam int CFG_SHORT_BIT = 0;

endpackage

// File: rtl/tdm_cfg_regs.sv
module tdm_cfg_regs
    import tdm_tx_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int STAT_W     = 16,
    parameter int CFG_ADDR   = 12,
    parameter int DEAD_ADDR0 = 14,
    parameter int DEAD_ADDR1 = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              mce,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STAT_W-1:0] status_word,
    output logic [STAT_W-1:0] rd_data,
    output tx_cfg_t           cfg_next,
    output logic              act_short_frame
);

    localparam logic [DATA_W-1:0] LIVE_MASK =
        DATA_W'((1 << (CFG_GRP_BIT + 1)) - 1);

    typedef struct packed {
        logic [DATA_W-1:0] shadow;
        tx_cfg_t           active;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       hit_cfg;
    logic       hit_dead;

    always_comb begin
        hit_cfg  = (addr == ADDR_W'(CFG_ADDR));
        hit_dead = (addr == ADDR_W'(DEAD_ADDR0)) || (addr == ADDR_W'(DEAD_ADDR1));
        st_d     = st_q;
        // commit uses the shadow as it stood before this cycle's write
        if (commit) begin
            st_d.active.grp_low     = st_q.shadow[CFG_GRP_BIT];
            st_d.active.short_frame = st_q.shadow[CFG_SHORT_BIT];
        end
        if (wr_en && mce && hit_cfg) begin
            st_d.shadow = wr_data & LIVE_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (hit_cfg) begin
            rd_data = STAT_W'(st_q.shadow);
        end else if (hit_dead) begin
            rd_data = status_word;
        end else begin
            rd_data = '0;
        end
    end

    assign cfg_next        = st_d.active;
    assign act_short_frame = st_q.active.short_frame;

    AST_GATED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mce) |=> $stable(st_q.shadow)); // R2

    AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(st_q.active)); // R3

    AST_DEAD_ADDR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_dead) |=> $stable(st_q.shadow)); // R9

endmodule

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
    parameter int SLOT_W       = 16,
    parameter int SLOTS_PERIOD = 16,
    parameter int LONG_PERIODS = 2
) (
    input  logic                                                 clk,
    input  logic                                                 rst_n,
    input  logic                                                 fsync,
    input  logic                                                 short_frame,
    output logic [$clog2(SLOT_W*SLOTS_PERIOD*LONG_PERIODS)-1:0]  pos_next,
    output logic                                                 live_next,
    output logic                                                 live_q_o
);

    localparam int PERIOD_BITS = SLOT_W * SLOTS_PERIOD;
    localparam int FRAME_MAX   = PERIOD_BITS * LONG_PERIODS;
    localparam int POS_W       = $clog2(FRAME_MAX);
    localparam logic [POS_W-1:0] LAST_SHORT = POS_W'(PERIOD_BITS - 1);
    localparam logic [POS_W-1:0] LAST_LONG  = POS_W'(FRAME_MAX - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             live;
    } tim_state_t;

    tim_state_t t_d, t_q;
    logic [POS_W-1:0] last_pos;

    always_comb begin
        last_pos = short_frame ? LAST_SHORT : LAST_LONG;
        t_d      = t_q;
        if (fsync) begin
            t_d.pos  = '0;
            t_d.live = 1'b1;
        end else if (t_q.live) begin
            if (t_q.pos == last_pos) begin
                t_d.live = 1'b0;
            end else begin
                t_d.pos = t_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign pos_next  = t_d.pos;
    assign live_next = t_d.live;
    assign live_q_o  = t_q.live;

    AST_FSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (t_q.pos == '0 && t_q.live)); // R7

endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter
    import tdm_tx_pkg::*;
#(
    parameter int SLOT_W       = 16,
    parameter int SLOTS_PERIOD = 16,
    parameter int LONG_PERIODS = 2,
    parameter int WORDS        = 3,
    parameter int BASE_HIGH    = 3,
    parameter int BASE_LOW     = 0
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic [$clog2(SLOT_W*SLOTS_PERIOD*LONG_PERIODS)-1:0] pos_next,
    input  logic                                                live_next,
    input  tx_cfg_t                                             cfg_next,
    input  logic [WORDS*SLOT_W-1:0]                             words_in,
    output logic                                                sdo,
    output logic                                                sdo_oe
);

    localparam int PERIOD_BITS = SLOT_W * SLOTS_PERIOD;
    localparam int POS_W       = $clog2(PERIOD_BITS * LONG_PERIODS);
    localparam int PER_W       = $clog2(PERIOD_BITS);
    localparam int BIT_W       = $clog2(SLOT_W);
    localparam int SLOT_IDX_W  = PER_W - BIT_W;

    typedef struct packed {
        logic [WORDS-1:0][SLOT_W-1:0] hold;
        logic                         sdo;
        logic                         oe;
    } sh_state_t;

    sh_state_t s_d, s_q;

    logic [PER_W-1:0]      off;
    logic [SLOT_IDX_W-1:0] slot;
    logic [BIT_W-1:0]      bitp;
    logic                  first_period;
    logic                  allowed;
    int                    base;
    int                    rel;

    always_comb begin
        off          = pos_next[PER_W-1:0];
        slot         = off[PER_W-1:BIT_W];
        bitp         = off[BIT_W-1:0];
        first_period = (pos_next[POS_W-1:PER_W] == '0);
        allowed      = live_next && (first_period || !cfg_next.short_frame);
        base         = cfg_next.grp_low ? BASE_LOW : BASE_HIGH;
        rel          = int'(slot) - base;

        s_d = s_q;
        // capture the three words at the start of every sample period
        if (live_next && off == '0) begin
            for (int w = 0; w < WORDS; w++) begin
                s_d.hold[w] = words_in[w*SLOT_W +: SLOT_W];
            end
        end

        s_d.oe  = 1'b0;
        s_d.sdo = 1'b0;
        if (allowed && rel >= 0 && rel < WORDS) begin
            s_d.oe  = 1'b1;
            s_d.sdo = s_d.hold[rel][SLOT_W-1-int'(bitp)];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sdo    = s_q.sdo;
    assign sdo_oe = s_q.oe;

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
    import tdm_tx_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 8,
    parameter int SLOT_W       = 16,
    parameter int SLOTS_PERIOD = 16,
    parameter int LONG_PERIODS = 2,
    parameter int WORDS        = 3,
    parameter int BASE_HIGH    = 3,
    parameter int BASE_LOW     = 0,
    parameter int CFG_ADDR     = 12,
    parameter int DEAD_ADDR0   = 14,
    parameter int DEAD_ADDR1   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              mce,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SLOT_W-1:0] rd_data,
    input  logic [SLOT_W-1:0] status_word,
    input  logic [SLOT_W-1:0] left_word,
    input  logic [SLOT_W-1:0] right_word,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int POS_W = $clog2(SLOT_W * SLOTS_PERIOD * LONG_PERIODS);

    tx_cfg_t          cfg_next;
    logic             act_short;
    logic [POS_W-1:0] pos_next;
    logic             live_next;
    logic             live_q;
    logic [WORDS*SLOT_W-1:0] words_flat;

    assign words_flat = {right_word, left_word, status_word};

    tdm_cfg_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .STAT_W    (SLOT_W),
        .CFG_ADDR  (CFG_ADDR),
        .DEAD_ADDR0(DEAD_ADDR0),
        .DEAD_ADDR1(DEAD_ADDR1)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .commit         (fsync),
        .mce            (mce),
        .wr_en          (wr_en),
        .addr           (addr),
        .wr_data        (wr_data),
        .status_word    (status_word),
        .rd_data        (rd_data),
        .cfg_next       (cfg_next),
        .act_short_frame(act_short)
    );

    tdm_slot_timer #(
        .SLOT_W      (SLOT_W),
        .SLOTS_PERIOD(SLOTS_PERIOD),
        .LONG_PERIODS(LONG_PERIODS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .short_frame(act_short),
        .pos_next   (pos_next),
        .live_next  (live_next),
        .live_q_o   (live_q)
    );

    tdm_tx_shifter #(
        .SLOT_W      (SLOT_W),
        .SLOTS_PERIOD(SLOTS_PERIOD),
        .LONG_PERIODS(LONG_PERIODS),
        .WORDS       (WORDS),
        .BASE_HIGH   (BASE_HIGH),
        .BASE_LOW    (BASE_LOW)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos_next (pos_next),
        .live_next(live_next),
        .cfg_next (cfg_next),
        .words_in (words_flat),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    AST_OE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> live_q); // R11

endmodule

// File: tb/sim_tdm_slot_tx.sv
module sim_tdm_slot_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        mce = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd12;
    logic [7:0]  wr_data = 8'h00;
    logic [15:0] rd_data;
    logic [15:0] status_word = 16'hA5C3;
    logic [15:0] left_word = 16'h1234;
    logic [15:0] right_word = 16'hF00D;
    logic        sdo, sdo_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [3:0] rd_sel = 4'd12;

    always #5 clk = ~clk;

    tdm_slot_tx u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .mce(mce), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .status_word(status_word), .left_word(left_word), .right_word(right_word),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // ---------------- behavioural reference model ----------------
    int m_shadow = 0;
    int m_active = 0;
    int m_pos = 0;
    bit m_live = 1'b0;
    int m_words[3];
    bit m_oe;
    bit m_sdo;

    always @(posedge clk) begin
        int last, slot, bitn, half, base, off;
        if (!rst_n) begin
            m_shadow = 0; m_active = 0; m_pos = 0; m_live = 1'b0;
            m_words = '{0, 0, 0};
        end else begin
            if (fsync) begin
                m_active = m_shadow; m_pos = 0; m_live = 1'b1;
            end else if (m_live) begin
                last = (m_active % 2 == 1) ? 255 : 511;
                if (m_pos == last) m_live = 1'b0;
                else m_pos++;
            end
            if (wr_en && mce && addr == 4'd12) m_shadow = wr_data % 4;
            if (m_live && m_pos % 256 == 0) begin
                m_words[0] = status_word; m_words[1] = left_word; m_words[2] = right_word;
            end
        end
        off  = m_pos % 256;
        slot = off / 16;
        bitn = off % 16;
        half = m_pos / 256;
        base = (m_active / 2 == 1) ? 0 : 3;
        m_oe  = m_live && (half == 0 || m_active % 2 == 0) && slot >= base && slot < base + 3;
        m_sdo = m_oe ? m_words[slot - base][15 - bitn] : 1'b0;
        #3;
        if (rst_n && !done) begin
            // R4 R5 R6 R11: enable pattern; R7 R8: bit content
            n_checks++;
            if (sdo_oe !== m_oe) begin
                n_fail++;
                $display("FAIL R4 R5 R6 R11 sdo_oe pos=%0d act=%b exp=%b", m_pos, sdo_oe, m_oe);
            end
            if (m_oe) begin
                n_checks++;
                if (sdo !== m_sdo) begin
                    n_fail++;
                    $display("FAIL R7 R8 sdo pos=%0d act=%b exp=%b", m_pos, sdo, m_sdo);
                end
            end
            // R3 R9 R10 read path
            n_checks++;
            if (rd_data !== expect_rd(addr)) begin
                n_fail++;
                $display("FAIL R3 R9 R10 rd_data addr=%0d act=%h exp=%h", addr, rd_data, expect_rd(addr));
            end
        end
    end

    function automatic logic [15:0] expect_rd(logic [3:0] a);
        if (a == 4'd12) return 16'(m_shadow);
        if (a == 4'd14 || a == 4'd15) return status_word;
        return 16'h0000;
    endfunction

    // word inputs change in the middle of sample periods (R8)
    int wcnt = 0;
    always @(negedge clk) begin
        wcnt++;
        if (wcnt % 37 == 0) left_word = left_word + 16'h1357;
        if (wcnt % 53 == 0) right_word = right_word ^ 16'h5A3C;
        if (wcnt % 71 == 0) status_word = status_word + 16'h0F11;
    end

    task automatic check16(string tag, logic [15:0] act, logic [15:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    // one frame of len clocks; optional register write at position wpos
    task automatic frame(int len, int wpos, logic [3:0] wa, logic [7:0] wd, logic wm);
        for (int p = 0; p < len; p++) begin
            fsync   = (p == 0);
            wr_en   = (p == wpos);
            addr    = (p == wpos) ? wa : rd_sel;
            wr_data = wd;
            mce     = wm;
            @(negedge clk);
        end
        fsync = 1'b0; wr_en = 1'b0; mce = 1'b0; addr = rd_sel;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check16("R1 cfg readback", rd_data, 16'h0000);
        check16("R1 oe idle", {15'd0, sdo_oe}, 16'h0000);
        repeat (20) @(negedge clk);
        check16("R1 oe idle before fsync", {15'd0, sdo_oe}, 16'h0000);

        frame(512, -1, 4'd12, 8'h00, 1'b0);
        // R2: gated write ignored
        frame(512, 40, 4'd12, 8'h03, 1'b0);
        check16("R2 gated write readback", rd_data, 16'h0000);
        frame(512, -1, 4'd12, 8'h00, 1'b0);
        // R6: slot-group change in first half of a 32-slot frame
        frame(512, 100, 4'd12, 8'h02, 1'b1);
        check16("R3 accepted write readback", rd_data, 16'h0002);
        frame(512, -1, 4'd12, 8'h00, 1'b0);
        // R10: reserved bits dropped; written in second half (R3 deferral)
        frame(512, 300, 4'd12, 8'hFF, 1'b1);
        check16("R10 reserved bits zero", rd_data, 16'h0003);
        frame(256, -1, 4'd12, 8'h00, 1'b0);
        frame(256, -1, 4'd12, 8'h00, 1'b0);
        // R11: frame overrun without fsync in 16-slot mode
        frame(400, -1, 4'd12, 8'h00, 1'b0);
        check16("R11 oe low after frame end", {15'd0, sdo_oe}, 16'h0000);
        // R9: dead addresses
        frame(256, 50, 4'd14, 8'h00, 1'b1);
        frame(256, 60, 4'd15, 8'h01, 1'b1);
        check16("R9 dead write no effect", rd_data, 16'h0003);
        rd_sel = 4'd14; addr = rd_sel;
        @(negedge clk);
        check16("R9 read addr 14", rd_data, status_word);
        rd_sel = 4'd15; addr = rd_sel;
        @(negedge clk);
        check16("R9 read addr 15", rd_data, status_word);
        rd_sel = 4'd7; addr = rd_sel;
        @(negedge clk);
        check16("R9 read other addr", rd_data, 16'h0000);
        rd_sel = 4'd12; addr = rd_sel;
        // R3: write on the fsync cycle waits one more frame
        frame(256, 0, 4'd12, 8'h01, 1'b1);
        check16("R3 fsync-cycle write readback", rd_data, 16'h0001);
        frame(256, -1, 4'd12, 8'h00, 1'b0);
        frame(256, -1, 4'd12, 8'h00, 1'b0);
        // R4: back to 32-slot frames, then overrun in 32-slot mode
        frame(256, 10, 4'd12, 8'h00, 1'b1);
        frame(512, -1, 4'd12, 8'h00, 1'b0);
        frame(600, -1, 4'd12, 8'h00, 1'b0);
        // R6: frame-size change in first half keeps the second half
        frame(512, 20, 4'd12, 8'h01, 1'b1);
        frame(256, -1, 4'd12, 8'h00, 1'b0);
        frame(256, -1, 4'd12, 8'h00, 1'b0);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule